// File: doc/BRIEF.md
# Indirect Management Register Access Sequencer

This block sits on the host side of a management bus and turns one register request (read or write, a device address, a register address and, for writes, a data word) into the series of Clause 22 management transactions that a switch with indirect addressing expects. It does not drive MDC/MDIO itself. It hands each transaction to a separate frame master through a transaction port, and that master signals completion with a done pulse, read data and a failure flag.

When the configured chip address is zero, the switch answers on every bus address. The request then becomes a single transaction: the bus address is the device address and the register is the register address. For any other chip address the block goes through the chip's command register (offset 0) and data register (offset 1). It polls the command register until the busy flag is clear and moves the data through the data register. It then writes a command word and polls again. A poll that never sees busy clear within `POLL_LIMIT` reads ends the access with an error. A failed lower-level transaction also ends it with an error.

Requests and responses use valid/ready. A request is taken only while the block is idle. The response stays presented until the consumer accepts it, so a consumer that is not ready simply stalls the block. The transaction port is also valid/ready on the issue side, and its fields hold steady while the frame master withholds ready.

Top module: `smi_indirect_engine`

## Requirements
- R1: `req_ready` is high only while no access is in progress. A request is taken on the cycle where `req_valid` and `req_ready` are both high. No other request is taken until that access has returned its response.
- R2: With a chip address of zero, an access issues exactly one transaction to bus address `req_dev`, register `req_reg`, with the request's direction and write data. A read returns that transaction's data.
- R3: The command word for an indirect access is bit 15 set (busy), bits 14:13 zero, bit 12 set (Clause 22 marker), bits 11:10 the opcode (binary 10 for read, 01 for write), bits 9:5 the device address and bits 4:0 the register address. This gives 0x9800 or 0x9400 ORed with dev<<5 and reg.
- R4: An indirect read issues, in order: busy polls, a write of the read command to register 0, busy polls, then a read of register 1. It returns that read's 16 bits.
- R5: An indirect write issues, in order: busy polls, a write of the data to register 1, a write of the write command to register 0, then busy polls.
- R6: A busy poll is a read of register 0 at the chip address. Only bit 15 of the returned word is tested. Polling repeats while that bit is set and moves on after the first read where it is clear.
- R7: If `POLL_LIMIT` consecutive polls all return busy, no further transaction is issued and the response carries `rsp_err` = 1.
- R8: A transaction completing with `tx_fail` = 1 ends the access at once with `rsp_err` = 1. No further transaction is issued.
- R9: `rsp_valid`, `rsp_rdata` and `rsp_err` hold steady until `rsp_ready` is seen. `rsp_rdata` is zero on an error and on any write.
- R10: `tx_valid` and the transaction fields hold steady until `tx_ready` is seen. At most one transaction is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_addr | input | 5 | Chip bus address; zero selects direct access; sampled when a request is taken |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and taking a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Target device address |
| req_reg | input | 5 | Target register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 16 | Read data, zero on error or write |
| rsp_err | output | 1 | Timeout or transaction failure |
| tx_valid | output | 1 | Transaction request to the frame master |
| tx_ready | input | 1 | Frame master takes the transaction |
| tx_write | output | 1 | Transaction direction |
| tx_phy | output | 5 | Transaction bus address |
| tx_reg | output | 5 | Transaction register |
| tx_wdata | output | 16 | Transaction write data |
| tx_done | input | 1 | One-cycle completion of the outstanding transaction |
| tx_rdata | input | 16 | Transaction read data, valid with `tx_done` |
| tx_fail | input | 1 | Transaction failed, valid with `tx_done` |

## Verification
The bench sweeps both directions over every pair of busy-run lengths from zero up to one past the poll limit, for the polls before and after the command. This shows whether the pre- and post-command polls are counted separately and whether the limit is hit exactly at `POLL_LIMIT` reads. Busy replies set every bit while idle replies set all but bit 15, so a design that tests anything other than the busy bit is caught. A failure is injected at each position of a full sequence to confirm the abort point. Direct-mode accesses over a spread of addresses separate the bypass from the indirect path. Varied frame-master latency and ready gaps test that the issued fields stay stable.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int FIELD_W  = 5;
  localparam int WORD_W   = 16;
  localparam int BUSY_BIT = 15;
  localparam int MARK_BIT = 12;
  localparam int OP_LSB   = 10;
  localparam int DEV_LSB  = 5;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  localparam logic [FIELD_W-1:0] REG_CMD  = 5'd0;
  localparam logic [FIELD_W-1:0] REG_DATA = 5'd1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIRECT,
    ST_POLL_PRE,
    ST_DATA_WR,
    ST_CMD_WR,
    ST_POLL_POST,
    ST_DATA_RD,
    ST_RESP
  } seq_state_t;
endpackage

// File: rtl/smi_cmd_builder.sv
module smi_cmd_builder
  import smi_pkg::*;
(
  input  logic               is_write,
  input  logic [FIELD_W-1:0] dev,
  input  logic [FIELD_W-1:0] regno,
  output logic [WORD_W-1:0]  cmd
);
  always_comb begin
    cmd = '0;
    cmd[BUSY_BIT] = 1'b1;
    cmd[MARK_BIT] = 1'b1;
    cmd[OP_LSB +: 2] = is_write ? OP_WRITE : OP_READ;
    cmd[DEV_LSB +: FIELD_W] = dev;
    cmd[0 +: FIELD_W] = regno;
  end
endmodule

// File: rtl/smi_poll_counter.sv
module smi_poll_counter #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (inc && !last) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == LAST_VAL);
endmodule

// File: rtl/smi_txn_tracker.sv
module smi_txn_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tx_ready,
  input  logic tx_done,
  output logic tx_valid,
  output logic step
);
  logic inflight;

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= 1'b0;
    else if (tx_valid && tx_ready) inflight <= 1'b1;
    else if (tx_done) inflight <= 1'b0;
  end

  assign tx_valid = active && !inflight;
  assign step     = inflight && tx_done;
endmodule

// File: rtl/smi_indirect_engine.sv
module smi_indirect_engine
  import smi_pkg::*;
#(
  parameter int POLL_LIMIT = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [FIELD_W-1:0]  chip_addr,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [FIELD_W-1:0]  req_dev,
  input  logic [FIELD_W-1:0]  req_reg,
  input  logic [WORD_W-1:0]   req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [WORD_W-1:0]   rsp_rdata,
  output logic                rsp_err,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic                tx_write,
  output logic [FIELD_W-1:0]  tx_phy,
  output logic [FIELD_W-1:0]  tx_reg,
  output logic [WORD_W-1:0]   tx_wdata,
  input  logic                tx_done,
  input  logic [WORD_W-1:0]   tx_rdata,
  input  logic                tx_fail
);
  seq_state_t         st;
  logic               wr_q;
  logic [FIELD_W-1:0] dev_q, reg_q, chip_q;
  logic [WORD_W-1:0]  wd_q, rd_q;
  logic               err_q;

  logic               bus_state, poll_state, step, poll_last, busy_seen;
  logic [WORD_W-1:0]  cmd_word;

  assign bus_state  = (st != ST_IDLE) && (st != ST_RESP);
  assign poll_state = (st == ST_POLL_PRE) || (st == ST_POLL_POST);
  assign busy_seen  = tx_rdata[BUSY_BIT];

  smi_cmd_builder u_cmd (
    .is_write (wr_q),
    .dev      (dev_q),
    .regno    (reg_q),
    .cmd      (cmd_word)
  );

  smi_txn_tracker u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (bus_state),
    .tx_ready (tx_ready),
    .tx_done  (tx_done),
    .tx_valid (tx_valid),
    .step     (step)
  );

  smi_poll_counter #(.LIMIT(POLL_LIMIT)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!poll_state),
    .inc   (step && poll_state && busy_seen && !tx_fail),
    .last  (poll_last)
  );

  always_comb begin
    tx_write = 1'b0;
    tx_phy   = chip_q;
    tx_reg   = REG_CMD;
    tx_wdata = '0;
    unique case (st)
      ST_DIRECT: begin
        tx_write = wr_q;
        tx_phy   = dev_q;
        tx_reg   = reg_q;
        tx_wdata = wd_q;
      end
      ST_DATA_WR: begin
        tx_write = 1'b1;
        tx_reg   = REG_DATA;
        tx_wdata = wd_q;
      end
      ST_CMD_WR: begin
        tx_write = 1'b1;
        tx_wdata = cmd_word;
      end
      ST_DATA_RD: tx_reg = REG_DATA;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      wr_q   <= 1'b0;
      dev_q  <= '0;
      reg_q  <= '0;
      chip_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            wr_q   <= req_write;
            dev_q  <= req_dev;
            reg_q  <= req_reg;
            chip_q <= chip_addr;
            wd_q   <= req_wdata;
            rd_q   <= '0;
            err_q  <= 1'b0;
            st     <= (chip_addr == '0) ? ST_DIRECT : ST_POLL_PRE;
          end
        end
        ST_RESP: begin
          if (rsp_ready) st <= ST_IDLE;
        end
        default: begin
          if (step) begin
            if (tx_fail) begin
              err_q <= 1'b1;
              rd_q  <= '0;
              st    <= ST_RESP;
            end else begin
              unique case (st)
                ST_DIRECT: begin
                  rd_q <= wr_q ? '0 : tx_rdata;
                  st   <= ST_RESP;
                end
                ST_POLL_PRE: begin
                  if (!busy_seen)     st <= wr_q ? ST_DATA_WR : ST_CMD_WR;
                  else if (poll_last) begin
                    err_q <= 1'b1;
                    st    <= ST_RESP;
                  end
                end
                ST_DATA_WR: st <= ST_CMD_WR;
                ST_CMD_WR:  st <= ST_POLL_POST;
                ST_POLL_POST: begin
                  if (!busy_seen)     st <= wr_q ? ST_RESP : ST_DATA_RD;
                  else if (poll_last) begin
                    err_q <= 1'b1;
                    st    <= ST_RESP;
                  end
                end
                ST_DATA_RD: begin
                  rd_q <= tx_rdata;
                  st   <= ST_RESP;
                end
                default: st <= ST_IDLE;
              endcase
            end
          end
        end
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RESP);
  assign rsp_rdata = rd_q;
  assign rsp_err   = err_q;
endmodule

// File: rtl/smi_engine_checker.sv
module smi_engine_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  chip_addr,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [4:0]  req_dev,
  input logic [4:0]  req_reg,
  input logic [15:0] req_wdata,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_rdata,
  input logic        rsp_err,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        tx_write,
  input logic [4:0]  tx_phy,
  input logic [4:0]  tx_reg,
  input logic [15:0] tx_wdata,
  input logic        tx_done,
  input logic [15:0] tx_rdata,
  input logic        tx_fail
);
  logic       c_act, c_wr;
  logic [4:0] c_dev, c_reg, c_chip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_act <= 1'b0; c_wr <= 1'b0; c_dev <= '0; c_reg <= '0; c_chip <= '0;
    end else if (req_valid && req_ready) begin
      c_act <= 1'b1; c_wr <= req_write; c_dev <= req_dev;
      c_reg <= req_reg; c_chip <= chip_addr;
    end else if (rsp_valid && rsp_ready) begin
      c_act <= 1'b0;
    end
  end

  assert_idle_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!tx_valid && !rsp_valid));

  assert_direct_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && c_act && c_chip == 5'd0) |->
      (tx_phy == c_dev && tx_reg == c_reg && tx_write == c_wr));

  assert_cmd_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && c_act && c_chip != 5'd0 && tx_write && tx_reg == 5'd0) |->
      (tx_wdata == {1'b1, 2'b00, 1'b1, (c_wr ? 2'b01 : 2'b10), c_dev, c_reg}));

  assert_indirect_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && c_act && c_chip != 5'd0) |-> (tx_phy == c_chip && tx_reg <= 5'd1));

  assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == 16'h0000));

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=>
      (tx_valid && $stable(tx_phy) && $stable(tx_reg) && $stable(tx_wdata) && $stable(tx_write)));

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_valid);
endmodule

bind smi_indirect_engine smi_engine_checker u_chk (.*);

// File: tb/sim_smi_indirect_engine.sv
`timescale 1ns/1ps
module sim_smi_indirect_engine;
  localparam int LIM = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [4:0]  chip_addr = '0;
  logic        req_valid = 0, req_write = 0;
  logic [4:0]  req_dev = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_ready = 0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic        tx_valid, tx_write;
  logic [4:0]  tx_phy, tx_reg;
  logic [15:0] tx_wdata;
  logic        tx_ready = 0, tx_done = 0, tx_fail = 0;
  logic [15:0] tx_rdata = '0;

  smi_indirect_engine #(.POLL_LIMIT(LIM)) u0 (.*);

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // frame master model
  int cfg_lat = 0, cfg_gap = 0, cfg_b1 = 0, cfg_b2 = 0, cfg_fail_at = 99;
  logic [15:0] cfg_rd = 16'h0;
  int pend = 0, lat_cnt = 0, gap_cnt = 0, phase = 0, poll_i = 0, txn_i = 0;
  logic [15:0] r_rd;
  logic r_fail;
  logic lg_w [0:31];
  logic [4:0] lg_phy [0:31];
  logic [4:0] lg_reg [0:31];
  logic [15:0] lg_wd [0:31];
  int n_log = 0;
  logic pv_v = 0, pv_w;
  logic [4:0] pv_p, pv_r;
  logic [15:0] pv_d;

  always @(negedge clk) begin
    if (!rst_n) begin
      tx_ready = 0; tx_done = 0; tx_fail = 0; pend = 0;
    end else begin
      tx_done = 0; tx_fail = 0;
      if (pend != 0) begin
        tx_ready = 0;
        if (lat_cnt == 0) begin
          tx_done = 1; tx_rdata = r_rd; tx_fail = r_fail; pend = 0; gap_cnt = cfg_gap;
        end else lat_cnt--;
      end else if (gap_cnt > 0) begin
        tx_ready = 0; gap_cnt--;
        if (tx_valid && pv_v)
          check(pv_w == tx_write && pv_p == tx_phy && pv_r == tx_reg && pv_d == tx_wdata,
                "R10 tx fields stable", tx_wdata, pv_d);
      end else begin
        tx_ready = 1;
        if (tx_valid) begin
          bit is_poll, busy;
          if (n_log < 32) begin
            lg_w[n_log] = tx_write; lg_phy[n_log] = tx_phy;
            lg_reg[n_log] = tx_reg; lg_wd[n_log] = tx_wdata;
          end
          n_log++;
          is_poll = !tx_write && tx_reg == 5'd0 && chip_addr != 5'd0;
          busy = is_poll && (poll_i < ((phase == 0) ? cfg_b1 : cfg_b2));
          if (is_poll) poll_i++;
          if (tx_write && tx_reg == 5'd0) begin phase = 1; poll_i = 0; end
          r_rd = is_poll ? (busy ? 16'hFFFF : 16'h7FFF) : cfg_rd;
          r_fail = (txn_i == cfg_fail_at);
          txn_i++;
          pend = 1; lat_cnt = cfg_lat;
        end
      end
      pv_v = tx_valid; pv_w = tx_write; pv_p = tx_phy; pv_r = tx_reg; pv_d = tx_wdata;
    end
  end

  // expected transaction list
  logic ex_w [0:31];
  logic [4:0] ex_phy [0:31];
  logic [4:0] ex_reg [0:31];
  logic [15:0] ex_wd [0:31];
  int ex_len;
  bit exp_err;
  logic [15:0] exp_rd;

  task automatic add_ex(input logic w, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    ex_w[ex_len] = w; ex_phy[ex_len] = p; ex_reg[ex_len] = r; ex_wd[ex_len] = d;
    ex_len++;
  endtask

  task automatic add_polls(input int b, input logic [4:0] chip, output bit tmo);
    int n;
    n = (b < LIM) ? b + 1 : LIM;
    for (int i = 0; i < n; i++) add_ex(0, chip, 5'd0, 16'h0);
    tmo = (b >= LIM);
  endtask

  task automatic build_exp(input logic w, input logic [4:0] dev, input logic [4:0] rg,
                           input logic [15:0] wd, input logic [4:0] chip);
    bit tmo;
    logic [15:0] cmd;
    ex_len = 0; exp_err = 0;
    cmd = 16'h9000 | (w ? 16'h0400 : 16'h0800) | (16'(dev) << 5) | 16'(rg);
    if (chip == 5'd0) add_ex(w, dev, rg, wd);
    else begin
      add_polls(cfg_b1, chip, tmo);
      if (tmo) exp_err = 1;
      else begin
        if (w) add_ex(1, chip, 5'd1, wd);
        add_ex(1, chip, 5'd0, cmd);
        add_polls(cfg_b2, chip, tmo);
        if (tmo) exp_err = 1;
        else if (!w) add_ex(0, chip, 5'd1, 16'h0);
      end
    end
    if (cfg_fail_at < ex_len) begin ex_len = cfg_fail_at + 1; exp_err = 1; end
    exp_rd = (exp_err || w) ? 16'h0 : cfg_rd;
  endtask

  task automatic run_access(input logic w, input logic [4:0] dev, input logic [4:0] rg,
                            input logic [15:0] wd, input logic [4:0] chip, input string tag);
    logic [15:0] got_rd;
    logic got_err;
    @(negedge clk);
    n_log = 0; phase = 0; poll_i = 0; txn_i = 0; gap_cnt = cfg_gap;
    chip_addr = chip;
    build_exp(w, dev, rg, wd, chip);
    req_write = w; req_dev = dev; req_reg = rg; req_wdata = wd; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    check(req_ready == 0, "R1 busy after accept", req_ready, 0);
    while (!rsp_valid) begin
      if (req_ready) check(0, "R1 ready during access", 1, 0);
      @(negedge clk);
    end
    got_rd = rsp_rdata; got_err = rsp_err;
    repeat (2) @(negedge clk);
    check(rsp_valid && rsp_rdata == got_rd && rsp_err == got_err, "R9 response held", rsp_rdata, got_rd);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    check(req_ready && !rsp_valid, "R1 idle after response", req_ready, 1);
    check(n_log == ex_len, {tag, " transaction count"}, n_log, ex_len);
    for (int i = 0; i < ex_len && i < n_log; i++) begin
      check(lg_w[i] == ex_w[i] && lg_phy[i] == ex_phy[i] && lg_reg[i] == ex_reg[i],
            {tag, " R6 order/target"}, {lg_w[i], lg_phy[i], lg_reg[i]}, {ex_w[i], ex_phy[i], ex_reg[i]});
      if (ex_w[i]) check(lg_wd[i] == ex_wd[i], {tag, " R3 write word"}, lg_wd[i], ex_wd[i]);
    end
    check(got_err == exp_err, {tag, " R7 R8 error flag"}, got_err, exp_err);
    check(got_rd == exp_rd, {tag, " R9 read data"}, got_rd, exp_rd);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1 && tx_valid == 0 && rsp_valid == 0, "R1 reset state",
          {req_ready, tx_valid, rsp_valid}, 3'b100);

    // direct mode sweep (R2)
    for (int w = 0; w < 2; w++)
      for (int d = 0; d < 32; d += 7) begin
        cfg_lat = d % 3; cfg_gap = d % 2; cfg_fail_at = 99;
        cfg_rd = 16'hA500 ^ 16'(d * 37);
        run_access(w[0], d[4:0], 5'(31 - d), 16'h1234 + 16'(d), 5'd0, "R2 direct");
      end

    // indirect sweep over busy run lengths (R4 R5 R6 R7)
    for (int w = 0; w < 2; w++)
      for (int b1 = 0; b1 <= LIM + 1; b1++)
        for (int b2 = 0; b2 <= LIM + 1; b2++) begin
          cfg_b1 = b1; cfg_b2 = b2; cfg_fail_at = 99;
          cfg_lat = (b1 + b2) % 3; cfg_gap = b1 % 2;
          cfg_rd = 16'h0F0F ^ 16'(b1 * 256 + b2);
          run_access(w[0], 5'(b1 + 3), 5'(b2 + 9), 16'hC3A5 ^ 16'(b2), (b1 % 2 == 0) ? 5'd5 : 5'd31,
                     w ? "R5 indirect write" : "R4 indirect read");
        end

    // failure injection at every step (R8)
    for (int w = 0; w < 2; w++)
      for (int f = 0; f < 6; f++) begin
        cfg_b1 = 1; cfg_b2 = 1; cfg_fail_at = f; cfg_lat = 1; cfg_gap = 0;
        cfg_rd = 16'h5A5A;
        run_access(w[0], 5'd17, 5'd22, 16'hBEEF, 5'd9, "R8 fail abort");
      end
    cfg_fail_at = 0; cfg_b1 = 0; cfg_b2 = 0;
    run_access(1'b0, 5'd4, 5'd2, 16'h0, 5'd0, "R8 direct fail");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule